// File: doc/BRIEF.md
# Double-Width Funnel Shift Unit

This block is a combinational execution unit for a 64-bit integer pipeline. It decodes one 32-bit instruction word and carries out one of two double-word shifts that move bits across a pair of registers. Big-integer code uses these shifts to shift multi-word values one word at a time. The unit receives three register operand values from the issue stage. One operand supplies the upper word, one the lower word and one the shift count. It returns the 64-bit result together with a valid flag, which acts as the result write enable.

The datapath does not use a 128-bit barrel shifter. It first builds a bit mask from the shift count and uses the mask to merge the two words into one 64-bit value. A 64-bit rotator then turns that merged value into the final result. A record variant of each shift also produces a 4-bit condition field from a signed comparison of the result with zero. The incoming summary-overflow bit is copied into that field. Any instruction the unit does not own leaves all of its outputs idle.

Top module: `dws_funnel_unit`

## Requirements
- R1: `valid_o` is 1 exactly when `instr_i[31:26]` equals 4 and the extended opcode `instr_i[5:1]` is 26 (left shift) or 27 (right shift). Taken together with the record bit, the low six bits `instr_i[5:0]` read 52/53 for the left shift and 54/55 for the right shift.
- R2: `rc_i` is the upper word, `ra_i` is the lower word, and only `rb_i[5:0]` gives the shift count n (0..63). The bits `rb_i[63:6]` have no effect on any output.
- R3: For the left shift, `result_o` equals bits 127..64 of the 128-bit value {rc_i, ra_i} shifted left by n. When n = 0 the result is `rc_i` unchanged.
- R4: For the right shift, `result_o` equals bits 63..0 of {rc_i, ra_i} shifted right by n. When n = 0 the result is `ra_i` unchanged.
- R5: The register-number fields `instr_i[25:6]` have no effect on any output.
- R6: When `cr_we_o` is 1, `cr_o[3]` is 1 for a negative result, `cr_o[2]` is 1 for a positive result and `cr_o[1]` is 1 for a zero result, all judged as signed 64-bit values. Exactly one of these three bits is set, and `cr_o[0]` equals `so_i`.
- R7: `cr_we_o` equals `valid_o` AND `instr_i[0]`. The record bit does not change `result_o`.
- R8: When `valid_o` is 0, `result_o`, `cr_o` and `cr_we_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word. Bit 31 is the first bit in instruction order. |
| ra_i | input | 64 | Lower-word operand |
| rb_i | input | 64 | Shift-count operand. Only bits 5..0 are used. |
| rc_i | input | 64 | Upper-word operand |
| so_i | input | 1 | Summary-overflow bit, copied into the condition field |
| result_o | output | 64 | Shift result. It is zero when the instruction is not owned by this unit. |
| valid_o | output | 1 | Instruction owned by this unit; doubles as the result write enable |
| cr_o | output | 4 | Condition field {negative, positive, zero, summary overflow} |
| cr_we_o | output | 1 | Condition field write enable (record form) |

## Verification
The assertions run on every evaluation. They check the opcode decode, the coupling between the record bit and the condition write enable, and the quiet outputs for foreign instructions. They also check that the condition field has exactly one class bit, that this bit matches the sign and zero state of the result, and that a zero count passes the correct word through. Only the bench scenarios can show that every count from 0 to 63 yields the exact funnel-shifted value in both directions. Those scenarios use operand patterns that include all-ones, all-zeros and single-edge-bit words. They also show that the upper shift-count bits and the register-number fields have no effect.

// File: rtl/dws_pkg.sv
`timescale 1ns/1ps
package dws_pkg;

   typedef enum logic [1:0] {
      DWS_OP_NONE  = 2'd0,
      DWS_OP_LEFT  = 2'd1,
      DWS_OP_RIGHT = 2'd2
   } dws_op_e;

   typedef struct packed {
      logic neg;
      logic pos;
      logic zero;
      logic sovf;
   } dws_cr_t;

   localparam int unsigned DWS_INSTR_W = 32;

endpackage

// File: rtl/dws_decode.sv
`timescale 1ns/1ps
module dws_decode
   import dws_pkg::*;
#(
   parameter int PRIMARY_OP = 4,
   parameter int XO_LEFT    = 26,
   parameter int XO_RIGHT   = 27
) (
   input  logic [DWS_INSTR_W-1:0] instr_i,
   output dws_op_e                op_o,
   output logic                   rec_o
);

   // field positions, little-endian bit indices of the 32-bit word
   localparam int PO_MSB = DWS_INSTR_W - 1;
   localparam int PO_LSB = DWS_INSTR_W - 6;
   localparam int XO_MSB = 5;
   localparam int XO_LSB = 1;
   localparam int REC_BIT = 0;

   localparam logic [PO_MSB-PO_LSB:0] PO_CODE  = (PO_MSB-PO_LSB+1)'(PRIMARY_OP);
   localparam logic [XO_MSB-XO_LSB:0] XO_LCODE = (XO_MSB-XO_LSB+1)'(XO_LEFT);
   localparam logic [XO_MSB-XO_LSB:0] XO_RCODE = (XO_MSB-XO_LSB+1)'(XO_RIGHT);

   if (XO_LEFT == XO_RIGHT) begin : g_bad_xo_pair
      $error("dws_decode: left and right extended opcodes must differ");
   end
   if (XO_LEFT < 0 || XO_LEFT > 31 || XO_RIGHT < 0 || XO_RIGHT > 31) begin : g_bad_xo_range
      $error("dws_decode: extended opcodes must fit in five bits");
   end
   if (PRIMARY_OP < 0 || PRIMARY_OP > 63) begin : g_bad_po_range
      $error("dws_decode: primary opcode must fit in six bits");
   end

   logic [PO_MSB-PO_LSB:0] po_fld;
   logic [XO_MSB-XO_LSB:0] xo_fld;

   assign po_fld = instr_i[PO_MSB:PO_LSB];
   assign xo_fld = instr_i[XO_MSB:XO_LSB];

   always_comb begin
      op_o = DWS_OP_NONE;
      if (po_fld == PO_CODE) begin
         if (xo_fld == XO_LCODE) begin
            op_o = DWS_OP_LEFT;
         end else if (xo_fld == XO_RCODE) begin
            op_o = DWS_OP_RIGHT;
         end
      end
   end

   assign rec_o = instr_i[REC_BIT] && (op_o != DWS_OP_NONE);

endmodule

// File: rtl/dws_mask_gen.sv
`timescale 1ns/1ps
module dws_mask_gen #(
   parameter  int XLEN = 64,
   localparam int SHW  = $clog2(XLEN)
) (
   input  logic [SHW-1:0]  amt_i,
   input  logic            right_i,
   output logic [XLEN-1:0] mask_o
);

   localparam int             EW  = SHW + 1;
   localparam logic [EW-1:0]  TOP = EW'(XLEN - 1);

   logic [EW-1:0] amt_ext;
   assign amt_ext = {1'b0, amt_i};

   // left: low XLEN-n bits set; right: bits n and above set
   for (genvar i = 0; i < XLEN; i++) begin : g_bit
      localparam logic [EW-1:0] IDX = EW'(i);
      assign mask_o[i] = right_i ? (IDX >= amt_ext) : ((IDX + amt_ext) <= TOP);
   end

endmodule

// File: rtl/dws_rotator.sv
`timescale 1ns/1ps
module dws_rotator #(
   parameter  int XLEN   = 64,
   parameter  bit STAGED = 1'b1,
   localparam int SHW    = $clog2(XLEN)
) (
   input  logic [XLEN-1:0] data_i,
   input  logic [SHW-1:0]  amt_i,
   input  logic            right_i,
   output logic [XLEN-1:0] data_o
);

   // a right rotate by n is a left rotate by (XLEN - n) mod XLEN
   logic [SHW-1:0] lamt;
   assign lamt = right_i ? (~amt_i + SHW'(1)) : amt_i;

   if (STAGED) begin : g_staged
      logic [XLEN-1:0] stg [0:SHW];
      assign stg[0] = data_i;
      for (genvar s = 0; s < SHW; s++) begin : g_stage
         localparam int SH = 1 << s;
         assign stg[s+1] = lamt[s] ?
                           {stg[s][XLEN-1-SH:0], stg[s][XLEN-1:XLEN-SH]} :
                           stg[s];
      end
      assign data_o = stg[SHW];
   end else begin : g_flat
      logic [2*XLEN-1:0] dbl;
      assign dbl    = {data_i, data_i} << lamt;
      assign data_o = dbl[2*XLEN-1:XLEN];
   end

endmodule

// File: rtl/dws_cr_gen.sv
`timescale 1ns/1ps
module dws_cr_gen
   import dws_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [XLEN-1:0] val_i,
   input  logic            so_i,
   output dws_cr_t         cr_o
);

   logic is_zero;
   assign is_zero = (val_i == '0);

   always_comb begin
      cr_o.neg  = val_i[XLEN-1];
      cr_o.zero = is_zero;
      cr_o.pos  = !val_i[XLEN-1] && !is_zero;
      cr_o.sovf = so_i;
   end

endmodule

// File: rtl/dws_funnel_unit.sv
`timescale 1ns/1ps
module dws_funnel_unit
   import dws_pkg::*;
#(
   parameter  int XLEN       = 64,
   parameter  int PRIMARY_OP = 4,
   parameter  int XO_LEFT    = 26,
   parameter  int XO_RIGHT   = 27,
   parameter  bit ROT_STAGED = 1'b1,
   localparam int SHW        = $clog2(XLEN)
) (
   input  logic [DWS_INSTR_W-1:0] instr_i,
   input  logic [XLEN-1:0]        ra_i,
   input  logic [XLEN-1:0]        rb_i,
   input  logic [XLEN-1:0]        rc_i,
   input  logic                   so_i,
   output logic [XLEN-1:0]        result_o,
   output logic                   valid_o,
   output logic [3:0]             cr_o,
   output logic                   cr_we_o
);

   if (XLEN < 8 || (1 << SHW) != XLEN) begin : g_bad_xlen
      $error("dws_funnel_unit: XLEN must be a power of two, at least 8");
   end

   dws_op_e         op;
   logic            rec;
   logic            go_right;
   logic [SHW-1:0]  amt;
   logic [XLEN-1:0] mask;
   logic [XLEN-1:0] merged;
   logic [XLEN-1:0] rotated;
   dws_cr_t         cr_raw;

   dws_decode #(
      .PRIMARY_OP (PRIMARY_OP),
      .XO_LEFT    (XO_LEFT),
      .XO_RIGHT   (XO_RIGHT)
   ) i_decode (
      .instr_i (instr_i),
      .op_o    (op),
      .rec_o   (rec)
   );

   assign go_right = (op == DWS_OP_RIGHT);
   assign amt      = rb_i[SHW-1:0];

   dws_mask_gen #(.XLEN(XLEN)) i_mask (
      .amt_i   (amt),
      .right_i (go_right),
      .mask_o  (mask)
   );

   // mask-selected bits come from the word that survives in place
   assign merged = go_right ? ((rc_i & ~mask) | (ra_i & mask))
                            : ((rc_i & mask) | (ra_i & ~mask));

   dws_rotator #(.XLEN(XLEN), .STAGED(ROT_STAGED)) i_rot (
      .data_i  (merged),
      .amt_i   (amt),
      .right_i (go_right),
      .data_o  (rotated)
   );

   dws_cr_gen #(.XLEN(XLEN)) i_cr (
      .val_i (rotated),
      .so_i  (so_i),
      .cr_o  (cr_raw)
   );

   assign valid_o  = (op != DWS_OP_NONE);
   assign cr_we_o  = rec;
   assign result_o = valid_o ? rotated : '0;
   assign cr_o     = cr_we_o ? cr_raw : 4'b0000;

endmodule

// File: rtl/dws_funnel_checker.sv
`timescale 1ns/1ps
module dws_funnel_checker #(
   parameter  int XLEN       = 64,
   parameter  int PRIMARY_OP = 4,
   parameter  int XO_LEFT    = 26,
   parameter  int XO_RIGHT   = 27,
   localparam int SHW        = $clog2(XLEN)
) (
   input logic [31:0]     instr_i,
   input logic [XLEN-1:0] ra_i,
   input logic [XLEN-1:0] rb_i,
   input logic [XLEN-1:0] rc_i,
   input logic            so_i,
   input logic [XLEN-1:0] result_i,
   input logic            valid_i,
   input logic [3:0]      cr_i,
   input logic            cr_we_i
);

   logic owned_po, is_l, is_r, zero_amt;
   assign owned_po = (instr_i[31:26] == 6'(PRIMARY_OP));
   assign is_l     = owned_po && (instr_i[5:1] == 5'(XO_LEFT));
   assign is_r     = owned_po && (instr_i[5:1] == 5'(XO_RIGHT));
   assign zero_amt = (rb_i[SHW-1:0] == '0);

   always_comb begin
      p_decode_r1: assert (valid_i == (is_l || is_r))
         else $error("p_decode_r1 instr=%h", instr_i);
      p_rec_enable_r7: assert (cr_we_i == (valid_i && instr_i[0]))
         else $error("p_rec_enable_r7 instr=%h", instr_i);
      if (!valid_i) begin
         p_idle_outputs_r8: assert (result_i == '0 && cr_i == 4'b0000 && !cr_we_i)
            else $error("p_idle_outputs_r8 instr=%h", instr_i);
      end
      if (cr_we_i) begin
         p_cr_one_class_r6: assert ($countones(cr_i[3:1]) == 1 && cr_i[0] == so_i)
            else $error("p_cr_one_class_r6 cr=%b", cr_i);
         p_cr_sign_r6: assert (cr_i[3] == result_i[XLEN-1] && cr_i[1] == (result_i == '0))
            else $error("p_cr_sign_r6 cr=%b res=%h", cr_i, result_i);
      end
      if (is_l && zero_amt) begin
         p_zero_left_r3: assert (result_i == rc_i)
            else $error("p_zero_left_r3 rb=%h res=%h", rb_i, result_i);
      end
      if (is_r && zero_amt) begin
         p_zero_right_r4: assert (result_i == ra_i)
            else $error("p_zero_right_r4 rb=%h res=%h", rb_i, result_i);
      end
   end

endmodule

bind dws_funnel_unit dws_funnel_checker #(
   .XLEN       (XLEN),
   .PRIMARY_OP (PRIMARY_OP),
   .XO_LEFT    (XO_LEFT),
   .XO_RIGHT   (XO_RIGHT)
) i_dws_funnel_checker (
   .instr_i  (instr_i),
   .ra_i     (ra_i),
   .rb_i     (rb_i),
   .rc_i     (rc_i),
   .so_i     (so_i),
   .result_i (result_o),
   .valid_i  (valid_o),
   .cr_i     (cr_o),
   .cr_we_i  (cr_we_o)
);

// File: tb/test_dws_funnel_unit.sv
`timescale 1ns/1ps
module test_dws_funnel_unit;

   localparam int XLEN = 64;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [31:0]     instr;
   logic [XLEN-1:0] ra, rb, rc;
   logic            so;
   logic [XLEN-1:0] result;
   logic            valid;
   logic [3:0]      cr;
   logic            cr_we;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;
   logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

   always #2.5 clk = ~clk;

   dws_funnel_unit i_dws_funnel_unit (
      .instr_i  (instr),
      .ra_i     (ra),
      .rb_i     (rb),
      .rc_i     (rc),
      .so_i     (so),
      .result_o (result),
      .valid_o  (valid),
      .cr_o     (cr),
      .cr_we_o  (cr_we)
   );

   function automatic logic [63:0] next_rng(input logic [63:0] s);
      logic [63:0] x = s;
      x = x ^ (x << 13);
      x = x ^ (x >> 7);
      x = x ^ (x << 17);
      return x;
   endfunction

   function automatic logic [31:0] mk_instr(input logic [5:0] po, input logic [4:0] xo,
                                            input logic rec, input logic [19:0] regs);
      return {po, regs, xo, rec};
   endfunction

   function automatic logic [63:0] exp_shift(input bit right, input logic [63:0] hi,
                                             input logic [63:0] lo, input int n);
      logic [127:0] cat = {hi, lo};
      logic [127:0] sh;
      if (right) begin
         sh = cat >> n;
         return sh[63:0];
      end
      sh = cat << n;
      return sh[127:64];
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic apply(input logic [31:0] i_w, input logic [63:0] a, input logic [63:0] b,
                        input logic [63:0] c, input logic s);
      @(posedge clk);
      instr = i_w; ra = a; rb = b; rc = c; so = s;
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [63:0] hi, lo, er;
      logic [3:0]  ecr;
      instr = '0; ra = '0; rb = '0; rc = '0; so = 1'b0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      // reset / idle state: instruction word of zero is not owned (R8)
      apply(32'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h5, 64'h1234, 1'b1);
      check("R8 idle valid", {63'b0, valid}, 64'd0);
      check("R8 idle result", result, 64'd0);
      check("R8 idle cr", {59'b0, cr_we, cr}, 64'd0);

      // full sweep: direction x record bit x operand patterns x all counts
      for (int dir = 0; dir < 2; dir++) begin
         for (int rec = 0; rec < 2; rec++) begin
            for (int pat = 0; pat < 7; pat++) begin
               for (int n = 0; n < 64; n++) begin
                  logic [63:0] rb_v;
                  logic [19:0] regs;
                  string       rq;
                  case (pat)
                     0: begin hi = '1; lo = '0; end
                     1: begin hi = '0; lo = '1; end
                     2: begin hi = 64'h0123_4567_89AB_CDEF; lo = 64'hFEDC_BA98_7654_3210; end
                     3: begin hi = 64'h8000_0000_0000_0001; lo = 64'h8000_0000_0000_0001; end
                     4: begin hi = '0; lo = '0; end
                     default: begin
                        rng = next_rng(rng); hi = rng;
                        rng = next_rng(rng); lo = rng;
                     end
                  endcase
                  rng  = next_rng(rng);
                  rb_v = {rng[63:6], 6'(n)};   // R2: upper count bits random
                  regs = rng[19:0];            // R5: register fields random
                  apply(mk_instr(6'd4, (dir != 0) ? 5'd27 : 5'd26, rec[0], regs),
                        lo, rb_v, hi, n[0]);
                  er  = exp_shift(dir != 0, hi, lo, n);
                  ecr = {er[63], !er[63] && (er != 0), er == 0, n[0]};
                  rq  = (dir != 0) ? "R4 R2 R5" : "R3 R2 R5";
                  check({rq, " result"}, result, er);
                  check("R1 valid", {63'b0, valid}, 64'd1);
                  check("R7 cr_we", {63'b0, cr_we}, {63'b0, rec[0]});
                  if (rec != 0) check("R6 cr", {60'b0, cr}, {60'b0, ecr});
                  else          check("R7 cr idle", {60'b0, cr}, 64'd0);
               end
            end
         end
      end

      // explicit zero counts with large upper count bits (R3, R4, R2)
      apply(mk_instr(6'd4, 5'd26, 1'b0, 20'hABCDE), 64'h1111, 64'hFFFF_FFFF_FFFF_FFC0,
            64'h2222, 1'b0);
      check("R3 R2 zero count left", result, 64'h2222);
      apply(mk_instr(6'd4, 5'd27, 1'b0, 20'h12345), 64'h1111, 64'hFFFF_FFFF_FFFF_FFC0,
            64'h2222, 1'b0);
      check("R4 R2 zero count right", result, 64'h1111);

      // low six bits read 52..55 (R1)
      apply({6'd4, 20'h0, 6'd53}, 64'h1, 64'd1, 64'h0, 1'b0);
      check("R1 code 53 left rec", {62'b0, valid, cr_we}, 64'd3);
      check("R1 code 53 result", result, 64'd0);
      apply({6'd4, 20'h0, 6'd54}, 64'h2, 64'd1, 64'h0, 1'b0);
      check("R1 code 54 right", {62'b0, valid, cr_we}, 64'd2);
      check("R1 code 54 result", result, 64'd1);

      // foreign extended opcodes under the owned primary opcode (R8, R1)
      for (int xo = 0; xo < 32; xo++) begin
         if (xo != 26 && xo != 27) begin
            apply(mk_instr(6'd4, 5'(xo), 1'b1, 20'h5A5A5), '1, 64'd3, '1, 1'b1);
            check("R1 R8 foreign xo valid", {62'b0, valid, cr_we}, 64'd0);
            check("R8 foreign xo outputs", result | {60'b0, cr}, 64'd0);
         end
      end
      // foreign primary opcodes with an owned extended opcode (R8, R1)
      for (int po = 0; po < 64; po++) begin
         if (po != 4) begin
            apply(mk_instr(6'(po), 5'd26, 1'b1, 20'h0F0F0), '1, 64'd5, '1, 1'b1);
            check("R1 R8 foreign po valid", {62'b0, valid, cr_we}, 64'd0);
            check("R8 foreign po outputs", result | {60'b0, cr}, 64'd0);
         end
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule